// File: doc/BRIEF.md
# I2C multi-master bus state tracker

This block follows who holds a shared I2C bus, as seen from one master controller. It passes the raw SCL and SDA lines through a two-flop synchronizer and finds start and stop conditions on them. It also takes single-cycle pulses from the local controller: a local address write, which issues a start, a local stop command, an arbitration-lost indication and a software write that forces the idle state. From these inputs it keeps a four-state ownership code, which the rest of the master reads before it begins a transfer.

After the master is enabled, the bus state is unknown. The state becomes known through a stop seen on the wires, through a software force, or through an optional inactive-bus timeout. An internal counter measures how long both lines stay high, and the timeout fires when that time reaches a programmable limit. Once the state is known it never goes back to unknown, unless the master is disabled.

Top module: `i2c_bus_tracker`

## Requirements
- R1: Reset, and any cycle with `enable` low, puts `bus_state` to UNKNOWN on the next edge. The codes are UNKNOWN = 2'b00, IDLE = 2'b01, OWNER = 2'b10 and BUSY = 2'b11.
- R2: A start is SDA falling while SCL stays high, and a stop is SDA rising while SCL stays high. Both are judged on the synchronized lines. Each pulses `start_det` or `stop_det` high for one cycle, in the second cycle after the line changes. SDA changing while SCL is low produces no strobe.
- R3: In UNKNOWN, a detected stop moves the state to IDLE. The state change takes effect on the third clock edge after the SDA change.
- R4: When `force_idle` is high while enabled, the state is IDLE on the next edge, from any state. It takes priority over `addr_wr`, `stop_cmd` and `arb_lost` in the same cycle. While `enable` is low it has no effect.
- R5: In IDLE, a start detected on the bus moves the state to BUSY. In BUSY, a detected stop returns the state to IDLE.
- R6: In IDLE, `addr_wr` moves the state to OWNER on the next edge. In OWNER, `stop_cmd` returns the state to IDLE on the next edge. In OWNER, starts and stops seen on the bus leave the state unchanged.
- R7: In OWNER, `arb_lost` moves the state to BUSY on the next edge. In BUSY, `stop_cmd` has no effect, and the state stays BUSY until a stop is detected.
- R8: An `addr_wr` in OWNER (a repeated start) keeps the state OWNER. The same write arriving together with `arb_lost` moves the state to BUSY.
- R9: While `enable` stays high, the state never returns to UNKNOWN after it has left UNKNOWN.
- R10: With `tmo_en` high, the timeout fires after `tmo_limit` consecutive cycles in which both synchronized lines are high with no edge. It drives a one-cycle `tmo_pulse`, and the state moves from UNKNOWN or BUSY to IDLE. Any line edge, or `enable` low, restarts the count. With `tmo_en` low, no pulse occurs and the state is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Master enabled |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| addr_wr | input | 1 | Local address write (issues start or repeated start) |
| stop_cmd | input | 1 | Local stop command |
| arb_lost | input | 1 | Arbitration lost indication |
| force_idle | input | 1 | Software write forcing IDLE |
| tmo_en | input | 1 | Inactive-bus timeout enable |
| tmo_limit | input | TMO_W | Quiet cycles before the timeout fires (at least 1) |
| bus_state | output | 2 | Encoded bus ownership state |
| start_det | output | 1 | One-cycle start strobe |
| stop_det | output | 1 | One-cycle stop strobe |
| tmo_pulse | output | 1 | One-cycle timeout strobe |

## Verification
Wire waveforms move SDA in two ways: while SCL is high, and while SCL is low. This separates true start and stop conditions from ordinary data changes, and it pins the strobe and state latency to exact edges. The local pulses are applied both alone and combined: arbitration loss with a repeated start, and a software force together with an address write. These combinations show the repeated start is neutral unless arbitration is lost and that the force wins. Long quiet stretches are run with the timeout off and then on, and the state is checked a few cycles before and after the expected expiry. A running check watches every cycle for a return to UNKNOWN while the master stays enabled.

// File: rtl/i2c_bus_tracker.sv
module i2c_bus_tracker #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             addr_wr,
  input  logic             stop_cmd,
  input  logic             arb_lost,
  input  logic             force_idle,
  input  logic             tmo_en,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [1:0]       bus_state,
  output logic             start_det,
  output logic             stop_det,
  output logic             tmo_pulse
);

  typedef enum logic [1:0] {
    ST_UNKNOWN = 2'b00,
    ST_IDLE    = 2'b01,
    ST_OWNER   = 2'b10,
    ST_BUSY    = 2'b11
  } bus_st_t;

  logic [1:0]       scl_sync, sda_sync;
  logic             scl_q, sda_q;
  logic             scl_s, sda_s;
  logic             quiet;
  logic [TMO_W-1:0] quiet_cnt;
  bus_st_t          state, state_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign start_det = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;
  assign quiet     = scl_q & scl_s & sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet_cnt <= '0;
    else if (!enable || !quiet)
      quiet_cnt <= '0;
    else if (quiet_cnt != tmo_limit)
      quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign tmo_pulse = enable & tmo_en & quiet &
                     (quiet_cnt == TMO_W'(tmo_limit - 1'b1));

  always_comb begin
    state_nx = state;
    if (!enable)
      state_nx = ST_UNKNOWN;
    else if (force_idle)
      state_nx = ST_IDLE;
    else begin
      case (state)
        ST_UNKNOWN: if (stop_det || tmo_pulse) state_nx = ST_IDLE;
        ST_IDLE:    if (addr_wr) state_nx = ST_OWNER;
                    else if (start_det) state_nx = ST_BUSY;
        ST_OWNER:   if (arb_lost) state_nx = ST_BUSY;
                    else if (stop_cmd) state_nx = ST_IDLE;
        ST_BUSY:    if (stop_det || tmo_pulse) state_nx = ST_IDLE;
        default:    state_nx = ST_UNKNOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_UNKNOWN;
    else        state <= state_nx;
  end

  assign bus_state = state;

  assert_disable_unknown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> bus_state == 2'b00);

  assert_force_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && force_idle) |=> bus_state == 2'b01);

  assert_local_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !force_idle && bus_state == 2'b01 && addr_wr) |=> bus_state == 2'b10);

  assert_arb_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !force_idle && bus_state == 2'b10 && arb_lost) |=> bus_state == 2'b11);

  assert_no_unknown_reentry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && bus_state != 2'b00) |=> (!enable || bus_state != 2'b00));

  assert_timeout_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_en |-> !tmo_pulse);

endmodule

// File: tb/tb_i2c_bus_tracker.sv
`timescale 1ns/1ps
module tb_i2c_bus_tracker;
  localparam int TMO_W = 16;
  localparam int LIM   = 20;
  localparam logic [1:0] UNK = 2'b00, IDL = 2'b01, OWN = 2'b10, BSY = 2'b11;

  logic clk = 0, rst_n = 0, enable = 0;
  logic scl_in = 1, sda_in = 1;
  logic addr_wr = 0, stop_cmd = 0, arb_lost = 0, force_idle = 0, tmo_en = 0;
  logic [TMO_W-1:0] tmo_limit = TMO_W'(LIM);
  logic [1:0] bus_state;
  logic start_det, stop_det, tmo_pulse;

  int checks = 0, errors = 0;
  bit left_unk = 0, tmo_seen = 0, reentry = 0;

  always #2 clk = ~clk;

  i2c_bus_tracker #(.TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
    .addr_wr(addr_wr), .stop_cmd(stop_cmd), .arb_lost(arb_lost),
    .force_idle(force_idle), .tmo_en(tmo_en), .tmo_limit(tmo_limit),
    .bus_state(bus_state), .start_det(start_det), .stop_det(stop_det),
    .tmo_pulse(tmo_pulse));

  always @(negedge clk) begin
    if (tmo_pulse) tmo_seen = 1;
    if (!enable || !rst_n) left_unk = 0;
    else if (bus_state != UNK) left_unk = 1;
    else if (left_unk) reentry = 1;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(input bit a, input bit s, input bit l, input bit f);
    addr_wr = a; stop_cmd = s; arb_lost = l; force_idle = f;
    step(1);
    addr_wr = 0; stop_cmd = 0; arb_lost = 0; force_idle = 0;
  endtask

  task automatic bus_stop();
    scl_in = 0; step(4); sda_in = 0; step(4); scl_in = 1; step(4);
    sda_in = 1;
  endtask

  task automatic t_reset();
    chk("R1 reset state", bus_state, UNK);
    chk("R2 no strobes at reset", {start_det, stop_det}, 2'b00);
  endtask

  task automatic t_timeout_off();
    tmo_seen = 0;
    step(3 * LIM);
    chk("R10 disabled timeout keeps UNKNOWN", bus_state, UNK);
    chk("R10 disabled timeout no pulse", {1'b0, tmo_seen}, 2'b00);
  endtask

  task automatic t_stop_from_unknown();
    scl_in = 0; step(4); sda_in = 0; step(4);
    chk("R2 SDA change with SCL low no strobe", {start_det, stop_det}, 2'b00);
    scl_in = 1; step(4);
    chk("R3 still UNKNOWN before stop", bus_state, UNK);
    sda_in = 1; step(1);
    chk("R2 stop not yet", {1'b0, stop_det}, 2'b00);
    step(1);
    chk("R2 stop strobe", {start_det, stop_det}, 2'b01);
    chk("R3 state before update", bus_state, UNK);
    step(1);
    chk("R2 stop strobe one cycle", {1'b0, stop_det}, 2'b00);
    chk("R3 stop moves UNKNOWN to IDLE", bus_state, IDL);
  endtask

  task automatic t_external();
    sda_in = 0; step(2);
    chk("R2 start strobe", {start_det, stop_det}, 2'b10);
    chk("R5 IDLE before update", bus_state, IDL);
    step(1);
    chk("R5 external start to BUSY", bus_state, BSY);
    chk("R2 start strobe one cycle", {1'b0, start_det}, 2'b00);
    scl_in = 0; step(4); scl_in = 1; step(4);
    chk("R5 BUSY held without stop", bus_state, BSY);
    sda_in = 1; step(3);
    chk("R5 stop returns BUSY to IDLE", bus_state, IDL);
  endtask

  task automatic t_local();
    pulse(1, 0, 0, 0);
    chk("R6 addr write to OWNER", bus_state, OWN);
    sda_in = 0; step(4);
    chk("R6 own start on bus keeps OWNER", bus_state, OWN);
    pulse(1, 0, 0, 0);
    chk("R8 repeated start keeps OWNER", bus_state, OWN);
    bus_stop(); step(4);
    chk("R6 bus stop in OWNER keeps OWNER", bus_state, OWN);
    pulse(0, 1, 0, 0);
    chk("R6 stop command to IDLE", bus_state, IDL);
  endtask

  task automatic t_arb();
    pulse(1, 0, 0, 0);
    chk("R7 OWNER before loss", bus_state, OWN);
    pulse(0, 0, 1, 0);
    chk("R7 arbitration lost to BUSY", bus_state, BSY);
    pulse(0, 1, 0, 0);
    chk("R7 stop command ignored in BUSY", bus_state, BSY);
    bus_stop(); step(3);
    chk("R7 bus stop leaves BUSY", bus_state, IDL);
  endtask

  task automatic t_rs_arb();
    pulse(1, 0, 0, 0);
    pulse(1, 0, 1, 0);
    chk("R8 repeated start with arbitration lost to BUSY", bus_state, BSY);
  endtask

  task automatic t_timeout_busy();
    tmo_en = 1; tmo_seen = 0;
    scl_in = 0; step(4); scl_in = 1;
    step(LIM + 1);
    chk("R10 BUSY before expiry", bus_state, BSY);
    chk("R10 no pulse before expiry", {1'b0, tmo_seen}, 2'b00);
    step(4);
    chk("R10 timeout BUSY to IDLE", bus_state, IDL);
    chk("R10 pulse seen", {1'b0, tmo_seen}, 2'b01);
  endtask

  task automatic t_force();
    pulse(1, 0, 0, 1);
    chk("R4 force beats addr write", bus_state, IDL);
    pulse(1, 0, 0, 0);
    pulse(0, 0, 1, 1);
    chk("R4 force beats arbitration lost in OWNER", bus_state, IDL);
  endtask

  task automatic t_disable();
    pulse(1, 0, 0, 0);
    enable = 0; step(1);
    chk("R1 disable to UNKNOWN", bus_state, UNK);
    pulse(0, 0, 0, 1);
    chk("R4 force ignored while disabled", bus_state, UNK);
    enable = 1; step(LIM - 2);
    chk("R9 re-enable stays UNKNOWN", bus_state, UNK);
    step(5);
    chk("R10 timeout UNKNOWN to IDLE", bus_state, IDL);
    tmo_en = 0;
    enable = 0; step(1); enable = 1; step(1);
    pulse(0, 0, 0, 1);
    chk("R4 force UNKNOWN to IDLE", bus_state, IDL);
  endtask

  initial begin
    step(2); rst_n = 1; enable = 1; step(1);
    t_reset();
    t_timeout_off();
    t_stop_from_unknown();
    t_external();
    t_local();
    t_arb();
    t_rs_arb();
    t_timeout_busy();
    t_force();
    t_disable();
    chk("R9 no UNKNOWN re-entry while enabled", {1'b0, reentry}, 2'b00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule